// File: doc/BRIEF.md
# Stereo Soft and Automatic Mute Controller

This block sits in the digital audio path of a stereo converter and scales every left/right sample pair by a shared gain. The gain moves between zero and unity in equal steps, one step per sample, so muting and unmuting fade the signal instead of cutting it. Nothing changes between samples: the gain, the zero-run count and the outputs are updated only when a sample pair is presented.

The mute control pin has three states. In the block it appears as a drive-enable input and a level input. When the pin is driven low, muting is released and the gain moves to unity. When it is driven high, a soft mute fades the gain to zero. When it is left undriven, automatic mute is selected. In that mode the block counts consecutive sample pairs in which both channels are zero. Once the count reaches the run length, it fades the output out. It exposes its automatic-mute state on an output, plus an enable that tells the pad to drive that state weakly back onto the pin only while nobody else drives it.

Top module: `mute_ctl_top`

## Requirements
- R1: While reset is asserted, and after its release, both sample outputs and `out_valid` are 0, `auto_mute_out` is 0, the zero-run count is 0 and the gain is unity (RAMP_STEPS).
- R2: With `mute_drive_en`=1 and `mute_level`=0, the target is unmuted. The gain rises by one per sample until it reaches unity, and a run of zero samples never lowers it.
- R3: With `mute_drive_en`=1 and `mute_level`=1, the gain drops by one per sample until it reaches zero and then stays at zero.
- R4: With `mute_drive_en`=0, `auto_mute_out` goes to 1 in the cycle after the RUN_LEN-th consecutive sample pair in which both channels are zero. From the next sample on, the gain drops by one per sample.
- R5: A sample pair with either channel nonzero clears the zero-run count, and `auto_mute_out` is 0 in the following cycle.
- R6: The zero-run count saturates at RUN_LEN. Further zero pairs keep `auto_mute_out` at 1 and never wrap the count.
- R7: When the mute target is released, the gain rises by exactly one per sample, so a full fade takes RAMP_STEPS samples in each direction.
- R8: Each output is the input sample multiplied by the gain that applied before the sample, arithmetically shifted right by log2(RAMP_STEPS) (rounding toward minus infinity) and truncated to DW bits. It appears, together with `out_valid`=1, one clock after `sample_valid`.
- R9: The mute state changes only at sample boundaries. Without `sample_valid`, changes on the control inputs leave the gain unchanged and `out_valid` low.
- R10: `auto_mute_weak_en` equals the inverse of `mute_drive_en`. `auto_mute_out` carries the automatic-mute state in every control state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | One-cycle strobe marking a new left/right sample pair |
| left_in | input | DW | Left sample, two's complement |
| right_in | input | DW | Right sample, two's complement |
| mute_drive_en | input | 1 | 1 when the mute pin is actively driven |
| mute_level | input | 1 | Level on the mute pin when driven (1 = mute) |
| left_out | output | DW | Scaled left sample |
| right_out | output | DW | Scaled right sample |
| out_valid | output | 1 | High for one cycle when new scaled samples are present |
| auto_mute_out | output | 1 | Automatic-mute state for the weak pin drive |
| auto_mute_weak_en | output | 1 | Enable for the weak pin drive, active while the pin is undriven |

## Verification
The bench builds the block with DW=18, RUN_LEN=8 and RAMP_STEPS=16. With these values a full fade takes only sixteen samples and automatic mute engages after eight zero pairs. This puts full fade-out and fade-in, saturation of the zero-run count, a nonzero sample at the last position before the count completes, and mid-fade reversals within a short run. The shift of four bits still exercises the rounding of negative products and the exact unity pass-through at full gain.

// File: rtl/mute_ctl_pkg.sv
package mute_ctl_pkg;

  typedef enum logic [1:0] {
    SEL_RELEASE = 2'd0,
    SEL_FORCE   = 2'd1,
    SEL_AUTO    = 2'd2
  } mute_sel_e;

  function automatic mute_sel_e decode_sel(input logic drive_en, input logic level);
    if (!drive_en)  return SEL_AUTO;
    else if (level) return SEL_FORCE;
    else            return SEL_RELEASE;
  endfunction

endpackage

// File: rtl/zero_run_detect.sv
module zero_run_detect #(
  parameter int DW      = 18,
  parameter int RUN_LEN = 64,
  localparam int CW     = $clog2(RUN_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_en,
  input  logic signed [DW-1:0] left_smp,
  input  logic signed [DW-1:0] right_smp,
  output logic [CW-1:0]        run_cnt,
  output logic                 auto_mute
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          both_zero;

  assign both_zero = (left_smp == '0) && (right_smp == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (smp_en) begin
      if (!both_zero)                 cnt_d = '0;
      else if (cnt_q != CW'(RUN_LEN)) cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign run_cnt   = cnt_q;
  assign auto_mute = (cnt_q == CW'(RUN_LEN));

endmodule

// File: rtl/gain_ramp.sv
module gain_ramp #(
  parameter int STEPS = 256,
  localparam int GW   = $clog2(STEPS) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en,
  input  logic          mute_req,
  output logic [GW-1:0] gain
);

  logic [GW-1:0] gain_q, gain_d;

  always_comb begin
    gain_d = gain_q;
    if (smp_en) begin
      if (mute_req && gain_q != '0)                   gain_d = gain_q - GW'(1);
      else if (!mute_req && gain_q != GW'(STEPS))     gain_d = gain_q + GW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gain_q <= GW'(STEPS);
    else        gain_q <= gain_d;
  end

  assign gain = gain_q;

endmodule

// File: rtl/sample_scaler.sv
module sample_scaler #(
  parameter int DW = 18,
  parameter int GW = 9,
  parameter int SH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_en,
  input  logic signed [DW-1:0] din,
  input  logic [GW-1:0]        gain,
  output logic signed [DW-1:0] dout
);

  localparam int PW = DW + GW + 1;

  logic signed [PW-1:0] prod;
  logic signed [DW-1:0] dout_q, dout_d;

  assign prod = PW'(din) * PW'($signed({1'b0, gain}));

  always_comb begin
    dout_d = dout_q;
    if (smp_en) dout_d = DW'(prod >>> SH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= dout_d;
  end

  assign dout = dout_q;

endmodule

// File: rtl/mute_ctl_top.sv
module mute_ctl_top #(
  parameter int DW         = 18,
  parameter int RUN_LEN    = 64,
  parameter int RAMP_STEPS = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_valid,
  input  logic signed [DW-1:0] left_in,
  input  logic signed [DW-1:0] right_in,
  input  logic                 mute_drive_en,
  input  logic                 mute_level,
  output logic signed [DW-1:0] left_out,
  output logic signed [DW-1:0] right_out,
  output logic                 out_valid,
  output logic                 auto_mute_out,
  output logic                 auto_mute_weak_en
);
  import mute_ctl_pkg::*;

  localparam int GW = $clog2(RAMP_STEPS) + 1;
  localparam int SH = $clog2(RAMP_STEPS);
  localparam int CW = $clog2(RUN_LEN + 1);

  logic [GW-1:0]        gain;
  logic [CW-1:0]        run_cnt;
  logic                 auto_mute;
  logic                 mute_req;
  logic                 vld_q;
  mute_sel_e            sel;
  logic signed [DW-1:0] ch_in  [2];
  logic signed [DW-1:0] ch_out [2];

  assign sel = decode_sel(mute_drive_en, mute_level);

  always_comb begin
    case (sel)
      SEL_FORCE:   mute_req = 1'b1;
      SEL_AUTO:    mute_req = auto_mute;
      default:     mute_req = 1'b0;
    endcase
  end

  zero_run_detect #(.DW(DW), .RUN_LEN(RUN_LEN)) u_zrun (
    .clk(clk), .rst_n(rst_n), .smp_en(sample_valid),
    .left_smp(left_in), .right_smp(right_in),
    .run_cnt(run_cnt), .auto_mute(auto_mute)
  );

  gain_ramp #(.STEPS(RAMP_STEPS)) u_ramp (
    .clk(clk), .rst_n(rst_n), .smp_en(sample_valid),
    .mute_req(mute_req), .gain(gain)
  );

  assign ch_in[0] = left_in;
  assign ch_in[1] = right_in;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    sample_scaler #(.DW(DW), .GW(GW), .SH(SH)) u_scale (
      .clk(clk), .rst_n(rst_n), .smp_en(sample_valid),
      .din(ch_in[c]), .gain(gain), .dout(ch_out[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= sample_valid;
  end

  assign left_out          = ch_out[0];
  assign right_out         = ch_out[1];
  assign out_valid         = vld_q;
  assign auto_mute_out     = auto_mute;
  assign auto_mute_weak_en = ~mute_drive_en;

endmodule

// File: rtl/mute_ctl_checker.sv
module mute_ctl_checker #(
  parameter int DW         = 18,
  parameter int RUN_LEN    = 64,
  parameter int RAMP_STEPS = 256,
  localparam int GW        = $clog2(RAMP_STEPS) + 1,
  localparam int CW        = $clog2(RUN_LEN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sample_valid,
  input logic [DW-1:0] left_in,
  input logic [DW-1:0] right_in,
  input logic          mute_drive_en,
  input logic          mute_level,
  input logic          out_valid,
  input logic          auto_mute_out,
  input logic [GW-1:0] gain,
  input logic [CW-1:0] run_cnt
);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CW'(RUN_LEN));

  assert_nonzero_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && (left_in != '0 || right_in != '0)) |=> !auto_mute_out);

  assert_boundary_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(gain));

  assert_unit_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> (gain == $past(gain)) || (gain == $past(gain) + GW'(1))
                     || (gain + GW'(1) == $past(gain)));

  assert_release_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && mute_drive_en && !mute_level && gain == GW'(RAMP_STEPS))
      |=> gain == GW'(RAMP_STEPS));

  assert_force_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && mute_drive_en && mute_level && gain != '0)
      |=> gain + GW'(1) == $past(gain));

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> out_valid);

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> !out_valid);

endmodule

bind mute_ctl_top mute_ctl_checker #(
  .DW(DW), .RUN_LEN(RUN_LEN), .RAMP_STEPS(RAMP_STEPS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
  .left_in(left_in), .right_in(right_in),
  .mute_drive_en(mute_drive_en), .mute_level(mute_level),
  .out_valid(out_valid), .auto_mute_out(auto_mute_out),
  .gain(gain), .run_cnt(run_cnt)
);

// File: tb/mute_ctl_top_test.sv
module mute_ctl_top_test;

  localparam int DW    = 18;
  localparam int RUN   = 8;
  localparam int STEPS = 16;
  localparam int SH    = 4;
  localparam int NV    = 12;
  localparam int VW    = 8 + 2 + 2 * DW;

  // entry: {repeat, drive_en, level, left, right}
  localparam logic [VW-1:0] VEC [NV] = '{
    {8'd4,  1'b1, 1'b0,  18'sd1000,  -18'sd500},  // R8 unity pass-through
    {8'd20, 1'b1, 1'b0,  18'sd0,      18'sd0},    // R2 zeros never mute
    {8'd20, 1'b1, 1'b1,  18'sd3000,  -18'sd3001}, // R3 fade out and hold
    {8'd20, 1'b1, 1'b0,  18'sd7,     -18'sd7},    // R7 fade in
    {8'd12, 1'b0, 1'b0,  18'sd0,      18'sd0},    // R4 auto engages
    {8'd6,  1'b0, 1'b1,  18'sd0,      18'sd0},    // R6 saturation
    {8'd1,  1'b0, 1'b0,  18'sd0,      18'sd5},    // R5 release
    {8'd20, 1'b0, 1'b0,  18'sd100,   -18'sd200},  // R7 fade back in
    {8'd7,  1'b0, 1'b0,  18'sd0,      18'sd0},    // R4 one short of run
    {8'd1,  1'b0, 1'b0, -18'sd9,      18'sd0},    // R5 break before run completes
    {8'd8,  1'b0, 1'b0,  18'sd0,      18'sd0},    // R4 exact run length
    {8'd5,  1'b1, 1'b1, -18'sd131072, 18'sd131071} // R3 extremes while forced
  };

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 sample_valid;
  logic signed [DW-1:0] left_in, right_in;
  logic                 mute_drive_en, mute_level;
  logic signed [DW-1:0] left_out, right_out;
  logic                 out_valid, auto_mute_out, auto_mute_weak_en;

  int errors = 0;
  int checks = 0;
  int m_gain, m_cnt;
  logic m_auto;

  always #10 clk = ~clk;

  mute_ctl_top #(.DW(DW), .RUN_LEN(RUN), .RAMP_STEPS(STEPS)) uut (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .left_in(left_in), .right_in(right_in),
    .mute_drive_en(mute_drive_en), .mute_level(mute_level),
    .left_out(left_out), .right_out(right_out), .out_valid(out_valid),
    .auto_mute_out(auto_mute_out), .auto_mute_weak_en(auto_mute_weak_en)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] scale(input logic signed [DW-1:0] s, input int g);
    longint p;
    p = (longint'(s) * longint'(g)) >>> SH;
    return p[DW-1:0];
  endfunction

  task automatic model_reset();
    m_gain = STEPS; m_cnt = 0; m_auto = 1'b0;
  endtask

  // Drive one sample at a falling edge, check at the next falling edge.
  task automatic send(input logic en, input logic lvl,
                      input logic signed [DW-1:0] l, input logic signed [DW-1:0] r,
                      input string req);
    logic [DW-1:0] el, er;
    logic tgt;
    el = scale(l, m_gain);
    er = scale(r, m_gain);
    tgt = en ? lvl : m_auto;
    if (tgt && m_gain > 0)          m_gain--;
    else if (!tgt && m_gain < STEPS) m_gain++;
    if (l == 0 && r == 0) m_cnt = (m_cnt < RUN) ? m_cnt + 1 : RUN;
    else                  m_cnt = 0;
    m_auto = (m_cnt == RUN);
    mute_drive_en = en; mute_level = lvl;
    left_in = l; right_in = r; sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
    check({req, " R8 left"},  longint'(left_out),  longint'($signed(el)));
    check({req, " R8 right"}, longint'(right_out), longint'($signed(er)));
    check({req, " R8 valid"}, out_valid, 1);
    check({req, " R4 auto"},  auto_mute_out, m_auto);
    check({req, " R10 weak"}, auto_mute_weak_en, !en);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sample_valid = 1'b0; left_in = '0; right_in = '0;
    mute_drive_en = 1'b1; mute_level = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 left",  left_out, 0);
    check("R1 right", right_out, 0);
    check("R1 valid", out_valid, 0);
    check("R1 auto",  auto_mute_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", out_valid, 0);

    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < int'(VEC[i][VW-1 -: 8]); k++) begin
        send(VEC[i][2*DW+1], VEC[i][2*DW],
             $signed(VEC[i][2*DW-1 -: DW]), $signed(VEC[i][DW-1:0]), "table");
        @(negedge clk);
        check("R9 valid idle", out_valid, 0);
      end
    end

    // R9: control toggles between samples must not move the gain
    repeat (4) send(1'b1, 1'b0, 18'sd16, 18'sd0, "R9 pre");  // gain partly up
    mute_drive_en = 1'b1; mute_level = 1'b1;
    repeat (10) @(negedge clk);
    mute_drive_en = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 no valid", out_valid, 0);
    send(1'b1, 1'b0, 18'sd16, -18'sd16, "R9 after toggles");

    // R6/R10: undriven auto state stays set through long zero run, weak enable low when driven
    repeat (RUN + 4) send(1'b0, 1'b0, 18'sd0, 18'sd0, "R6 long run");
    check("R6 auto held", auto_mute_out, 1);
    send(1'b1, 1'b0, 18'sd0, 18'sd0, "R10 driven low");
    check("R10 auto visible while driven", auto_mute_out, 1);

    // R1: reset mid-run restores unity and clears auto state
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset auto", auto_mute_out, 0);
    check("R1 mid reset left", left_out, 0);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    send(1'b0, 1'b0, -18'sd1234, 18'sd4321, "R1 unity after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule